// File: doc/BRIEF.md
# Single-Issue Warp Dispatcher with Three Execution Pipes

This block models the issue stage of one partition of a SIMT processor. A pool of resident warps (32 threads each) each present one pending instruction, described by a class code and a ready flag. On every clock the block grants at most one warp. It sends that warp's whole instruction to one of three execution pipes that have different capabilities. Each pipe then stays occupied for a fixed number of cycles, and that number depends on the instruction class.

The instruction's class decides the pipe. Integer work can use only the general pipe (pipe 0). Single-precision float work can use pipe 0 or the float-only pipe (pipe 1). Matrix and plain half-precision work can use only the tensor pipe (pipe 2). Only one issue can happen per cycle, so two float pipes with a two-cycle occupancy can both stay full only when issues to them alternate. A long matrix operation costs the float pipes one issue slot each time it is dispatched. Free-running counters record issued cycles, empty issue slots and the busy cycles of each pipe, so the overlap can be measured.

Top module: `warp_dispatcher`

## Requirements
- R1: At most one warp is granted per cycle, and a granted warp always has its ready flag set. A warp whose ready flag is low is never granted, even when a pipe that suits it is free.
- R2: The class codes are 3 bits wide: 0 is FP32, 1 is INT32, 2 is the 8-deep matrix op, 3 is the 16-deep matrix op and 4 is plain FP16. INT32 goes only to pipe 0. FP32 goes to pipe 0 or pipe 1. The two matrix classes and FP16 go only to pipe 2.
- R3: A warp is eligible only if it is ready and some pipe that accepts its class is idle in that cycle.
- R4: An FP32 or INT32 issue occupies its pipe for 2 cycles, counting the issue cycle. When both float pipes are idle, FP32 goes to pipe 1. It goes to pipe 0 only while pipe 1 is busy.
- R5: An 8-deep matrix op occupies pipe 2 for 8 cycles and a 16-deep matrix op for 16 cycles, counting the issue cycle.
- R6: A plain FP16 op occupies pipe 2 for 1 cycle, so pipe 2 can accept another instruction on the next cycle.
- R7: Eligible warps are granted round-robin. The search starts at the warp after the last granted one, and warp 0 is searched first after reset.
- R8: A cycle with no eligible warp is an empty issue slot. In that cycle the grant is low and the idle-slot counter advances.
- R9: The issued-cycle counter advances on every grant. Each pipe's busy counter advances on every cycle in which that pipe is occupied, including the cycle of the issue.
- R10: While reset is low, the grant is low, all pipes report idle and all counters read zero.
- R11: Class codes 5 to 7 are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_class | input | NUM_WARPS*3 | Per-warp class code; warp w occupies bits 3w+2..3w |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_warp | output | WID_W | Index of the granted warp |
| issue_pipe | output | 2 | Target pipe (0, 1 or 2) |
| pipe_busy | output | 3 | Per-pipe occupancy this cycle, including an issue now |
| cnt_issue | output | CNT_W | Cycles with an issue |
| cnt_idle | output | CNT_W | Empty issue slots |
| cnt_busy_a | output | CNT_W | Busy cycles of pipe 0 |
| cnt_busy_b | output | CNT_W | Busy cycles of pipe 1 |
| cnt_busy_t | output | CNT_W | Busy cycles of pipe 2 |

## Verification
The checks assume that the ready flags and class codes are stable for the whole clock period and change only between edges. The class of a granted warp must also be the one it holds in the cycle after the grant. The properties on occupancy after an issue rely on this, because they read the class back in the following cycle. The stimulus changes inputs only on falling edges, and holds each pattern fixed for a whole scenario or directed sequence. Reset is applied between patterns, so every counted interval starts from empty pipes.

// File: rtl/wd_pkg.sv
// Package: shared class encoding and pipe indices for the warp dispatcher.
// Assumes: class codes above CLS_FP16 are unused and never issue.
package wd_pkg;
    localparam int CLS_W     = 3;
    localparam int NUM_PIPES = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_FP32  = 3'd0,
        CLS_INT32 = 3'd1,
        CLS_MMA_S = 3'd2,
        CLS_MMA_L = 3'd3,
        CLS_FP16  = 3'd4
    } wclass_e;

    localparam logic [1:0] PIPE_GEN = 2'd0;
    localparam logic [1:0] PIPE_FLT = 2'd1;
    localparam logic [1:0] PIPE_TEN = 2'd2;
endpackage

// File: rtl/wd_route.sv
// Module: wd_route
// Maps one warp's class to a legal pipe, using the pipes that are idle
// this cycle, and gives the occupancy that the pipe will take.
// Assumes: pipe_free is the registered idle state of each pipe.
module wd_route #(
    parameter int LAT_FP32  = 2,
    parameter int LAT_INT32 = 2,
    parameter int LAT_MMA_S = 8,
    parameter int LAT_MMA_L = 16,
    parameter int LAT_FP16  = 1,
    parameter int LAT_W     = 5
) (
    input  logic [wd_pkg::CLS_W-1:0] cls,
    input  logic [2:0]               pipe_free,
    output logic                     can_issue,
    output logic [1:0]               pipe,
    output logic [LAT_W-1:0]         occ
);
    import wd_pkg::*;

    // Choose the target pipe and occupancy for this class.
    always_comb begin
        can_issue = 1'b0;
        pipe      = PIPE_GEN;
        occ       = LAT_W'(1);
        case (cls)
            CLS_FP32: begin
                occ = LAT_W'(LAT_FP32);
                if (pipe_free[PIPE_FLT]) begin
                    can_issue = 1'b1;
                    pipe      = PIPE_FLT;
                end else if (pipe_free[PIPE_GEN]) begin
                    can_issue = 1'b1;
                    pipe      = PIPE_GEN;
                end
            end
            CLS_INT32: begin
                occ       = LAT_W'(LAT_INT32);
                can_issue = pipe_free[PIPE_GEN];
                pipe      = PIPE_GEN;
            end
            CLS_MMA_S: begin
                occ       = LAT_W'(LAT_MMA_S);
                can_issue = pipe_free[PIPE_TEN];
                pipe      = PIPE_TEN;
            end
            CLS_MMA_L: begin
                occ       = LAT_W'(LAT_MMA_L);
                can_issue = pipe_free[PIPE_TEN];
                pipe      = PIPE_TEN;
            end
            CLS_FP16: begin
                occ       = LAT_W'(LAT_FP16);
                can_issue = pipe_free[PIPE_TEN];
                pipe      = PIPE_TEN;
            end
            default: can_issue = 1'b0;
        endcase
    end
endmodule

// File: rtl/wd_rr_pick.sv
// Module: wd_rr_pick
// Round-robin grant over N requesters. The search starts one past the
// last granted index. After reset, index 0 is searched first.
// Assumes: advance is high only in cycles where the grant is used.
module wd_rr_pick #(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    // Scan requesters in rotating order from last_q+1.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(last_q) + k;
            if (c >= N) c = c - N;
            if (!gnt_valid && req[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(c);
            end
        end
    end

    // Remember the most recent grant as the rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= IDX_W'(N - 1);
        else if (advance) last_q <= gnt_idx;
    end
endmodule

// File: rtl/wd_pipe_timer.sv
// Module: wd_pipe_timer
// Occupancy down-counter for one pipe. On an issue it is loaded with
// the occupancy minus one, so the issue cycle itself counts as busy.
// Assumes: load_val is at least 1 whenever load is high.
module wd_pipe_timer #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             busy_q
);
    logic [LAT_W-1:0] remain_q;

    // Load on issue, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain_q <= '0;
        else if (load)           remain_q <= load_val - LAT_W'(1);
        else if (remain_q != '0) remain_q <= remain_q - LAT_W'(1);
    end

    assign busy_q = (remain_q != '0);
endmodule

// File: rtl/wd_event_cnt.sv
// Module: wd_event_cnt
// Free-running event counter. It counts one per cycle while hit is high
// and wraps at its width.
module wd_event_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    // Accumulate cycles in which the event is present.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (hit) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/warp_dispatcher.sv
// Module: warp_dispatcher (top)
// Single-issue dispatcher for one SIMT partition. Each cycle it grants at
// most one ready warp whose class has an idle legal pipe, routes that
// warp to the pipe and starts the pipe's occupancy timer. It also counts
// issues, empty slots and per-pipe busy cycles.
// Assumes: warp inputs are stable across each clock period.
module warp_dispatcher #(
    parameter int NUM_WARPS = 12,
    parameter int CNT_W     = 32,
    parameter int LAT_FP32  = 2,
    parameter int LAT_INT32 = 2,
    parameter int LAT_MMA_S = 8,
    parameter int LAT_MMA_L = 16,
    parameter int LAT_FP16  = 1,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int CLS_W    = wd_pkg::CLS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_WARPS-1:0]       warp_ready,
    input  logic [NUM_WARPS*CLS_W-1:0] warp_class,
    output logic                       issue_valid,
    output logic [WID_W-1:0]           issue_warp,
    output logic [1:0]                 issue_pipe,
    output logic [2:0]                 pipe_busy,
    output logic [CNT_W-1:0]           cnt_issue,
    output logic [CNT_W-1:0]           cnt_idle,
    output logic [CNT_W-1:0]           cnt_busy_a,
    output logic [CNT_W-1:0]           cnt_busy_b,
    output logic [CNT_W-1:0]           cnt_busy_t
);
    localparam int MAX_LAT01 = (LAT_FP32 > LAT_INT32) ? LAT_FP32 : LAT_INT32;
    localparam int MAX_LAT2A = (LAT_MMA_S > LAT_MMA_L) ? LAT_MMA_S : LAT_MMA_L;
    localparam int MAX_LAT2  = (MAX_LAT2A > LAT_FP16) ? MAX_LAT2A : LAT_FP16;
    localparam int MAX_LAT   = (MAX_LAT01 > MAX_LAT2) ? MAX_LAT01 : MAX_LAT2;
    localparam int LAT_W     = $clog2(MAX_LAT + 1);
    localparam int NP        = wd_pkg::NUM_PIPES;

    logic [NP-1:0]        pipe_busy_q;
    logic [NP-1:0]        pipe_free;
    logic [NP-1:0]        pipe_load;
    logic [NUM_WARPS-1:0] eligible;
    logic [1:0]           route_pipe [NUM_WARPS];
    logic [LAT_W-1:0]     route_occ  [NUM_WARPS];
    logic                 pick_valid;
    logic [WID_W-1:0]     pick_idx;
    logic [LAT_W-1:0]     issue_occ;

    assign pipe_free = ~pipe_busy_q;

    // One router per resident warp.
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        logic can_go;
        wd_route #(
            .LAT_FP32 (LAT_FP32),
            .LAT_INT32(LAT_INT32),
            .LAT_MMA_S(LAT_MMA_S),
            .LAT_MMA_L(LAT_MMA_L),
            .LAT_FP16 (LAT_FP16),
            .LAT_W    (LAT_W)
        ) u_route (
            .cls      (warp_class[g*CLS_W +: CLS_W]),
            .pipe_free(pipe_free),
            .can_issue(can_go),
            .pipe     (route_pipe[g]),
            .occ      (route_occ[g])
        );
        assign eligible[g] = warp_ready[g] & can_go;
    end

    wd_rr_pick #(
        .N    (NUM_WARPS),
        .IDX_W(WID_W)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (eligible),
        .advance  (issue_valid),
        .gnt_valid(pick_valid),
        .gnt_idx  (pick_idx)
    );

    // Issue outputs are taken from the granted warp's router.
    always_comb begin
        issue_valid = rst_n & pick_valid;
        issue_warp  = pick_idx;
        issue_pipe  = route_pipe[pick_idx];
        issue_occ   = route_occ[pick_idx];
    end

    // One occupancy timer per pipe.
    for (genvar p = 0; p < NP; p++) begin : g_pipe
        assign pipe_load[p] = issue_valid && (issue_pipe == 2'(p));
        wd_pipe_timer #(.LAT_W(LAT_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (pipe_load[p]),
            .load_val(issue_occ),
            .busy_q  (pipe_busy_q[p])
        );
    end

    assign pipe_busy = pipe_busy_q | pipe_load;

    wd_event_cnt #(.CNT_W(CNT_W)) u_cnt_iss (
        .clk(clk), .rst_n(rst_n), .hit(issue_valid), .count(cnt_issue));
    wd_event_cnt #(.CNT_W(CNT_W)) u_cnt_idle (
        .clk(clk), .rst_n(rst_n), .hit(rst_n & ~issue_valid), .count(cnt_idle));
    wd_event_cnt #(.CNT_W(CNT_W)) u_cnt_ba (
        .clk(clk), .rst_n(rst_n), .hit(pipe_busy[0]), .count(cnt_busy_a));
    wd_event_cnt #(.CNT_W(CNT_W)) u_cnt_bb (
        .clk(clk), .rst_n(rst_n), .hit(pipe_busy[1]), .count(cnt_busy_b));
    wd_event_cnt #(.CNT_W(CNT_W)) u_cnt_bt (
        .clk(clk), .rst_n(rst_n), .hit(pipe_busy[2]), .count(cnt_busy_t));
endmodule

// File: rtl/wd_checker.sv
// Module: wd_checker
// Temporal properties of the dispatcher, bound to the top module.
// Assumes: warp inputs are held stable across at least one edge after a grant.
module wd_checker #(
    parameter int NUM_WARPS = 12,
    parameter int CNT_W     = 32,
    parameter int WID_W     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_WARPS-1:0]         warp_ready,
    input logic [NUM_WARPS*3-1:0]       warp_class,
    input logic                         issue_valid,
    input logic [WID_W-1:0]             issue_warp,
    input logic [1:0]                   issue_pipe,
    input logic [2:0]                   pipe_busy,
    input logic [CNT_W-1:0]             cnt_issue,
    input logic [CNT_W-1:0]             cnt_idle
);
    import wd_pkg::*;

    logic [2:0] cur_cls;
    logic       past_ok;

    assign cur_cls = warp_class[int'(issue_warp)*3 +: 3];

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> warp_ready[issue_warp]);

    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((cur_cls == CLS_INT32 && issue_pipe == PIPE_GEN) ||
                         (cur_cls == CLS_FP32  && issue_pipe != PIPE_TEN) ||
                         ((cur_cls == CLS_MMA_S || cur_cls == CLS_MMA_L ||
                           cur_cls == CLS_FP16) && issue_pipe == PIPE_TEN)));

    assert_hold_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_pipe != PIPE_TEN)
        |=> !(issue_valid && issue_pipe == $past(issue_pipe)));

    assert_mma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (cur_cls == CLS_MMA_S || cur_cls == CLS_MMA_L))
        |=> (pipe_busy[2] && !(issue_valid && issue_pipe == PIPE_TEN)));

    assert_fp16_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cur_cls == CLS_FP16)
        |=> (pipe_busy[2] == (issue_valid && issue_pipe == PIPE_TEN)));

    assert_issue_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cnt_issue == $past(cnt_issue) + CNT_W'($past(issue_valid))));

    assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cnt_idle == $past(cnt_idle) + CNT_W'(!$past(issue_valid))));

    assert_no_bad_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (cur_cls <= 3'd4));
endmodule

bind warp_dispatcher wd_checker #(
    .NUM_WARPS(NUM_WARPS),
    .CNT_W    (CNT_W),
    .WID_W    (WID_W)
) u_wd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warp_ready (warp_ready),
    .warp_class (warp_class),
    .issue_valid(issue_valid),
    .issue_warp (issue_warp),
    .issue_pipe (issue_pipe),
    .pipe_busy  (pipe_busy),
    .cnt_issue  (cnt_issue),
    .cnt_idle   (cnt_idle)
);

// File: tb/tb_warp_dispatcher.sv
// Bench for warp_dispatcher: a table of counted scenarios followed by
// directed cycle-by-cycle tests of reset, routing and rotation.
module tb_warp_dispatcher;
    localparam int NW = 12;

    typedef struct packed {
        logic [11:0] rdy;
        logic [35:0] cls;
        int          cyc;
        int          iss;
        int          idl;
        int          b0;
        int          b1;
        int          b2;
    } vec_t;

    // Classes: 0 FP32, 1 INT32, 2 short matrix, 3 long matrix, 4 FP16.
    localparam vec_t VECS [8] = '{
        '{12'h001, 36'h000000000, 10, 10,  0,  9, 10,  0}, // FP32 alternates pipes
        '{12'h001, 36'h000000001, 10,  5,  5, 10,  0,  0}, // INT32 on pipe 0 only
        '{12'h001, 36'h000000003, 32,  2, 30,  0,  0, 32}, // long matrix, 16 cycles
        '{12'h00F, 36'h000000003, 32, 32,  0, 28, 31, 32}, // matrix plus FP32 overlap
        '{12'h000, 36'h000000000,  8,  0,  8,  0,  0,  0}, // nothing ready
        '{12'h001, 36'h000000007,  8,  0,  8,  0,  0,  0}, // illegal class
        '{12'h003, 36'h000000004,  8,  8,  0,  0,  7,  4}, // FP16 with FP32
        '{12'h001, 36'h000000002, 16,  2, 14,  0,  0, 16}  // short matrix, 8 cycles
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] warp_ready = '0;
    logic [NW*3-1:0] warp_class = '0;
    logic          issue_valid;
    logic [3:0]    issue_warp;
    logic [1:0]    issue_pipe;
    logic [2:0]    pipe_busy;
    logic [31:0]   cnt_issue, cnt_idle, cnt_busy_a, cnt_busy_b, cnt_busy_t;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    warp_dispatcher dut (
        .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_class(warp_class),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pipe(issue_pipe),
        .pipe_busy(pipe_busy), .cnt_issue(cnt_issue), .cnt_idle(cnt_idle),
        .cnt_busy_a(cnt_busy_a), .cnt_busy_b(cnt_busy_b), .cnt_busy_t(cnt_busy_t));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply a pattern under reset, then release reset on a falling edge.
    task automatic restart(input logic [NW-1:0] rdy, input logic [NW*3-1:0] cls);
        @(negedge clk);
        rst_n      = 1'b0;
        warp_ready = rdy;
        warp_class = cls;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state, held low with a ready warp present.
        @(negedge clk);
        warp_ready = 12'h001;
        @(negedge clk);
        check("R10 issue_valid in reset", int'(issue_valid), 0);
        check("R10 pipe_busy in reset", int'(pipe_busy), 0);
        check("R10 cnt_issue in reset", int'(cnt_issue), 0);
        check("R10 cnt_idle in reset", int'(cnt_idle), 0);

        // Table walk: counters after a fixed number of cycles (R9 and others).
        for (int v = 0; v < 8; v++) begin
            restart(VECS[v].rdy, VECS[v].cls);
            repeat (VECS[v].cyc) @(posedge clk);
            @(negedge clk);
            check($sformatf("R9 vec%0d cnt_issue", v), int'(cnt_issue), VECS[v].iss);
            check($sformatf("R8 vec%0d cnt_idle", v), int'(cnt_idle), VECS[v].idl);
            check($sformatf("R4 vec%0d busy pipe0", v), int'(cnt_busy_a), VECS[v].b0);
            check($sformatf("R4 vec%0d busy pipe1", v), int'(cnt_busy_b), VECS[v].b1);
            check($sformatf("R5 R6 vec%0d busy pipe2", v), int'(cnt_busy_t), VECS[v].b2);
        end

        // R4: FP32 prefers pipe 1, falls back to pipe 0 while pipe 1 is busy.
        restart(12'h001, 36'h0);
        #1;
        check("R4 first FP32 pipe", int'(issue_pipe), 1);
        @(negedge clk);
        check("R4 second FP32 pipe", int'(issue_pipe), 0);

        // R2: INT32 goes to pipe 0 and waits while pipe 0 is busy.
        restart(12'h001, 36'h1);
        #1;
        check("R2 INT32 pipe", int'(issue_pipe), 0);
        @(negedge clk);
        check("R3 INT32 blocked while pipe0 busy", int'(issue_valid), 0);

        // R7: three FP16 warps rotate 0,1,2,0,1 on pipe 2.
        restart(12'h007, 36'h924);
        for (int k = 0; k < 5; k++) begin
            #1;
            check("R7 rotation warp", int'(issue_warp), k % 3);
            check("R2 FP16 pipe", int'(issue_pipe), 2);
            @(negedge clk);
        end

        // R1: warp 1 stalled, rotation skips it: 0,2,0,2.
        restart(12'h005, 36'h924);
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R1 stalled warp skipped", int'(issue_warp), (k % 2) * 2);
            @(negedge clk);
        end

        // R11: illegal class never granted at the port.
        restart(12'h001, 36'h5);
        #1;
        check("R11 class 5 not issued", int'(issue_valid), 0);
        @(negedge clk);
        check("R11 class 5 no busy pipe", int'(pipe_busy), 0);

        // R5: short matrix blocks pipe 2 for cycles 1..7, frees at cycle 8.
        restart(12'h001, 36'h2);
        repeat (7) @(negedge clk);
        check("R5 busy at cycle 7", int'(pipe_busy[2]), 1);
        check("R5 no reissue at cycle 7", int'(issue_valid), 0);
        @(negedge clk);
        check("R5 reissue at cycle 8", int'(issue_valid), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule